// File: doc/BRIEF.md
# Socket Card Status Change Interrupt Logic

This block serves one card socket. It resynchronises the socket's status pins: two card-detect lines, ready, write protect, power-on, and two battery-voltage lines. The first battery line doubles as the status-change line of an I/O card. Software sees the live pin levels through an interface status register. The block also watches the pins for events. When an event is enabled, it is latched into a change register, and an interrupt is raised while any enabled latched event is pending.

A control bit chooses how the battery lines are read. In memory-card mode they report battery-dead and battery-warning events, and the ready pin reports a ready event. In I/O-card mode the first battery line reports a card status-change event, and the battery-warning and ready events are suppressed. Reading the change register returns the pending events and clears them. Software does one discarding read after it changes the enables.

Registers are reached through a simple select, read-strobe and write-strobe port with a combinational read path. The register selects are: 0 for interface status (read only), 1 for change (read clears), 2 for change enable and 3 for control.

Top module: `csc_intr`

## Requirements
- R1: After reset the change, enable and control registers read 0 and `irq` is low.
- R2: The interface status register (select 0) shows the resynchronised pin levels. Bit 0 is battery line 1 / status-change, bit 1 is battery line 2, bits 2 and 3 are detect A and B, bit 4 is write protect, bit 5 is ready, bit 6 is power-on and bit 7 reads 0. The battery and status-change bits are shown raw, so a low level means the condition is active.
- R3: `card_present` is high only when detect A and detect B are both high.
- R4: Any change of the combined presence condition latches change bit 3 (detect) when enable bit 3 is set.
- R5: With control bit 0 clear (memory mode), a falling battery line 1 latches bit 0, a falling battery line 2 latches bit 1, and a rising ready latches bit 2. Each latches only when its enable bit at the same position is set.
- R6: With control bit 0 set (I/O mode), a falling status-change line (battery line 1) latches bit 0, and bits 1 and 2 never latch.
- R7: An event whose enable bit is clear is not latched and raises no interrupt.
- R8: `irq` is high while any latched bit has its enable set, and it stays high until the change register is read.
- R9: A read of select 1 returns the pending events in bits 3:0 and clears them. Selects 2 and 3 read back the last written enable (bits 3:0) and control (bit 0).
- R10: An event latched in the same cycle as a read of the change register stays pending after that read.
- R11: Clearing an enable does not discard a bit that is already latched. Only a read of the change register discards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_bvd1 | input | 1 | Battery line 1 / I/O status-change, active low |
| pin_bvd2 | input | 1 | Battery line 2, active low |
| pin_det_a | input | 1 | Card detect A, high when seated |
| pin_det_b | input | 1 | Card detect B, high when seated |
| pin_wp | input | 1 | Write protect |
| pin_ready | input | 1 | Card ready |
| pin_pwr | input | 1 | Socket power is on |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_sel |
| irq | output | 1 | Pending enabled event |
| card_present | output | 1 | Both detect lines high |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. This makes the pin-to-latch latency three clock edges, and the bench derives that latency from the same value. Knowing the latency lets the bench place a register read exactly on the edge where a new event latches, so the read-versus-event collision can be tested. It also covers the mode switch, which reinterprets the same battery pin, and the stale-event handling around changes to the enables.

// File: rtl/csc_intr.sv
module csc_intr #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_bvd1,
  input  logic       pin_bvd2,
  input  logic       pin_det_a,
  input  logic       pin_det_b,
  input  logic       pin_wp,
  input  logic       pin_ready,
  input  logic       pin_pwr,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       card_present
);
  localparam int NPIN = 7;
  localparam int NEV  = 4;
  localparam logic [1:0] SEL_STAT = 2'd0;
  localparam logic [1:0] SEL_CHG  = 2'd1;
  localparam logic [1:0] SEL_EN   = 2'd2;
  localparam logic [1:0] SEL_CTL  = 2'd3;

  logic [NPIN-1:0] raw, live, prev;
  logic [SYNC_STAGES-1:0][NPIN-1:0] sq;
  logic [NEV-1:0] chg, en, ev;
  logic io_mode, clr, pres_now, pres_old;

  assign raw = {pin_pwr, pin_ready, pin_wp, pin_det_b, pin_det_a, pin_bvd2, pin_bvd1};
  assign live = sq[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sq   <= '0;
      prev <= '0;
    end else begin
      sq   <= {sq[SYNC_STAGES-2:0], raw};
      prev <= live;
    end

  assign pres_now = live[2] & live[3];
  assign pres_old = prev[2] & prev[3];
  assign card_present = pres_now;

  assign ev[0] = prev[0] & ~live[0];
  assign ev[1] = ~io_mode & prev[1] & ~live[1];
  assign ev[2] = ~io_mode & live[5] & ~prev[5];
  assign ev[3] = pres_now ^ pres_old;

  assign clr = reg_rd && reg_sel == SEL_CHG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chg     <= '0;
      en      <= '0;
      io_mode <= 1'b0;
    end else begin
      chg <= (clr ? '0 : chg) | (ev & en);
      if (reg_wr && reg_sel == SEL_EN)  en      <= reg_wdata[NEV-1:0];
      if (reg_wr && reg_sel == SEL_CTL) io_mode <= reg_wdata[0];
    end

  assign irq = |(chg & en);

  always_comb
    case (reg_sel)
      SEL_STAT: reg_rdata = {1'b0, live};
      SEL_CHG:  reg_rdata = {{(8-NEV){1'b0}}, chg};
      SEL_EN:   reg_rdata = {{(8-NEV){1'b0}}, en};
      default:  reg_rdata = {7'b0, io_mode};
    endcase

  p_clear_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (ev & en) == '0) |=> chg == '0);
  p_enabled_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((chg & ~$past(chg) & ~$past(en)) == '0));
  p_io_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_mode |=> ((chg[2:1] & ~$past(chg[2:1])) == 2'b0));
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr && !reg_wr) |=> irq);
  p_keep_coincident_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (ev & en) != '0) |=> chg != '0);
endmodule

// File: tb/csc_intr_test.sv
module csc_intr_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int LAT = SYNC + 1;

  logic clk = 0, rst_n = 0;
  logic bvd1 = 1, bvd2 = 1, det_a = 0, det_b = 0, wp = 0, rdy = 0, pwr = 0;
  logic [1:0] sel = 0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, present;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csc_intr #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .pin_bvd1(bvd1), .pin_bvd2(bvd2),
    .pin_det_a(det_a), .pin_det_b(det_b), .pin_wp(wp), .pin_ready(rdy),
    .pin_pwr(pwr), .reg_sel(sel), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .card_present(present));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); sel = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'b0, irq}, 8'h00);
    rreg(2'd1, d); check("R1 change", d, 8'h00);
    rreg(2'd2, d); check("R1 enable", d, 8'h00);
    rreg(2'd3, d); check("R1 control", d, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk); det_a = 1; det_b = 0; wp = 1; pwr = 1; rdy = 1; bvd1 = 0; bvd2 = 1;
    settle();
    rreg(2'd0, d); check("R2 status", d, 8'h77 & 8'b0111_0110);
    check("R3 one detect", {7'b0, present}, 8'h00);
    @(negedge clk); det_b = 1; rdy = 0; bvd1 = 1; wp = 0;
    settle();
    rreg(2'd0, d); check("R2 status", d, 8'h4F);
    check("R3 both detect", {7'b0, present}, 8'h01);
  endtask

  task automatic t_detect();
    logic [7:0] d;
    wreg(2'd2, 8'h08); rreg(2'd1, d);
    @(negedge clk); det_a = 0;
    settle();
    check("R8 irq set", {7'b0, irq}, 8'h01);
    rreg(2'd1, d); check("R4 detect", d, 8'h08);
    check("R8 irq cleared", {7'b0, irq}, 8'h00);
    rreg(2'd1, d); check("R9 cleared", d, 8'h00);
    rreg(2'd2, d); check("R9 enable readback", d, 8'h08);
    @(negedge clk); det_a = 1;
    settle(); rreg(2'd1, d); check("R4 insert", d, 8'h08);
  endtask

  task automatic t_mem();
    logic [7:0] d;
    wreg(2'd2, 8'h07); rreg(2'd1, d);
    @(negedge clk); bvd1 = 0; bvd2 = 0; rdy = 1;
    settle();
    rreg(2'd1, d); check("R5 mem events", d, 8'h07);
    @(negedge clk); bvd1 = 1; bvd2 = 1; rdy = 0;
    settle();
    rreg(2'd1, d); check("R5 no event on release", d, 8'h00);
  endtask

  task automatic t_io();
    logic [7:0] d;
    wreg(2'd3, 8'h01); rreg(2'd3, d); check("R9 control readback", d, 8'h01);
    @(negedge clk); bvd2 = 0; rdy = 1;
    settle();
    rreg(2'd1, d); check("R6 io suppressed", d, 8'h00);
    @(negedge clk); bvd1 = 0;
    settle();
    rreg(2'd1, d); check("R6 io status change", d, 8'h01);
    @(negedge clk); bvd1 = 1; bvd2 = 1; rdy = 0;
    wreg(2'd3, 8'h00); settle(); rreg(2'd1, d);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wreg(2'd2, 8'h00);
    @(negedge clk); det_b = 0; bvd1 = 0;
    settle();
    check("R7 no irq", {7'b0, irq}, 8'h00);
    rreg(2'd1, d); check("R7 not latched", d, 8'h00);
    @(negedge clk); det_b = 1; bvd1 = 1; settle();
  endtask

  task automatic t_hold();
    logic [7:0] d;
    wreg(2'd2, 8'h08); rreg(2'd1, d);
    @(negedge clk); det_a = 0;
    settle();
    repeat (20) @(negedge clk);
    check("R8 irq held", {7'b0, irq}, 8'h01);
    rreg(2'd1, d);
    check("R8 irq drops after read", {7'b0, irq}, 8'h00);
    @(negedge clk); det_a = 1; settle(); rreg(2'd1, d);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    wreg(2'd2, 8'h0C); rreg(2'd1, d);
    @(negedge clk); det_a = 0;
    settle();
    @(negedge clk); rdy = 1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk); sel = 2'd1; rd = 1; #1 d = rdata;
    check("R10 old event read", d, 8'h08);
    @(negedge clk); rd = 0;
    check("R10 irq kept", {7'b0, irq}, 8'h01);
    rreg(2'd1, d); check("R10 new event kept", d, 8'h04);
    @(negedge clk); det_a = 1; rdy = 0; settle(); rreg(2'd1, d);
  endtask

  task automatic t_stale();
    logic [7:0] d;
    wreg(2'd2, 8'h08); rreg(2'd1, d);
    @(negedge clk); det_b = 0;
    settle();
    wreg(2'd2, 8'h00);
    check("R11 masked irq", {7'b0, irq}, 8'h00);
    wreg(2'd2, 8'h08);
    check("R11 stale kept", {7'b0, irq}, 8'h01);
    rreg(2'd1, d); check("R11 stale value", d, 8'h08);
    check("R11 discarded", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_status();
    t_detect();
    t_mem();
    t_io();
    t_disabled();
    t_hold();
    t_coincide();
    t_stale();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule